// File: doc/BRIEF.md
# Interrupt Request Aggregator with Sleep Wake-Up

This block gathers interrupt requests from a small microcontroller's sources and reduces them to one interrupt line toward the CPU and one wake-up line toward the power controller. Three core sources feed it: an asynchronous external pin with a programmable active edge, a pulse that marks an 8-bit timer rolling over, and a pulse from port-change detection. A parameterised group of peripheral request pulses also feeds it. Every source latches into a sticky flag that only software can clear. Each flag has its own enable. The peripheral flags pass through an extra group enable before they join the core sources.

A global enable, held inside the block, gates only the CPU interrupt line. The wake-up line uses the same enabled-flag logic without the global term. A sleeping core therefore wakes on any enabled source, and the global enable then decides whether the core jumps to the vector or carries on in line. When the CPU acknowledges an interrupt, the global enable clears itself. A return-from-interrupt strobe sets it again. While the CPU line is asserted, the block presents the vector address.

Top module: `intc_top`

## Requirements
- R1: The external pin is synchronised and watched for one edge only. When `ext_rise_sel` is 1 a 0-to-1 change sets core flag bit 0. When it is 0 a 1-to-0 change sets that flag. The opposite edge is ignored.
- R2: If the external pin changes between two clock edges, core flag bit 0 is still 0 after the second rising clock edge that follows. It reads 1 after the third.
- R3: A flag that is set stays set until its own bit in `core_clr` or `per_clr` is pulsed high for one cycle. The flag then reads 0 after that edge.
- R4: The core flags have fixed bit positions: bit 0 is the external pin, bit 1 is timer roll-over (`tmr_wrap`) and bit 2 is port change (`port_chg`). Peripheral flag bit i is set by `per_req[i]`. A one-cycle high pulse sets the flag at the next edge.
- R5: `irq_cpu` = `gie` AND (OR of core_flags & core_en, OR (`per_grp_en` AND OR of per_flags & per_en)).
- R6: `wake` is the same expression as in R5 without the `gie` term, so it can be high while `gie` is 0.
- R7: With `per_grp_en` low, no peripheral flag can drive `irq_cpu` or `wake`, whatever `per_en` holds.
- R8: If a flag's set pulse and its clear strobe arrive in the same cycle, the flag reads 1 afterwards.
- R9: `gie` resets to 0. `irq_ack` clears it at the next edge and `reti` sets it. When both are absent, `gie_wr` loads `gie_wdata`. The priority order is `irq_ack` first, then `reti`, then `gie_wr`.
- R10: `vec_addr` equals 0x0004 while `irq_cpu` is high and 0 otherwise.
- R11: After reset all flags, `gie`, `irq_cpu`, `wake` and `vec_addr` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| ext_rise_sel | input | 1 | 1: rising edge active, 0: falling edge active |
| tmr_wrap | input | 1 | One-cycle pulse on timer roll-over |
| port_chg | input | 1 | One-cycle pulse on port change |
| per_req | input | NUM_PER | Peripheral request pulses |
| core_en | input | 3 | Enables for core flags |
| per_en | input | NUM_PER | Enables for peripheral flags |
| per_grp_en | input | 1 | Peripheral group enable |
| core_clr | input | 3 | Per-bit clear strobes for core flags |
| per_clr | input | NUM_PER | Per-bit clear strobes for peripheral flags |
| gie_wr | input | 1 | Write strobe for the global enable |
| gie_wdata | input | 1 | Value written to the global enable |
| irq_ack | input | 1 | CPU takes the interrupt |
| reti | input | 1 | Return-from-interrupt strobe |
| core_flags | output | 3 | Core sticky flags |
| per_flags | output | NUM_PER | Peripheral sticky flags |
| gie | output | 1 | Global interrupt enable |
| irq_cpu | output | 1 | Interrupt request to the CPU |
| wake | output | 1 | Wake-up request |
| vec_addr | output | VEC_W | Vector address while interrupting |

## Verification
On every cycle the embedded properties check four things. Flags never drop without a clear strobe, and a set beats a clear. The edge detector only emits single-cycle pulses. The CPU line never rises without both `gie` and `wake`, and an acknowledge always leaves `gie` low. The rest can only be shown by the bench's scenarios. These are the exact formula over every flag and enable combination, the two-versus-three edge latency of the pin, the ignored opposite edge, and the priority among acknowledge, return and write.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int CORE_N    = 3;
    localparam int CORE_EXT  = 0;
    localparam int CORE_TMR  = 1;
    localparam int CORE_PORT = 2;

    typedef struct packed {
        logic gie;
    } intc_state_t;
endpackage

// File: rtl/intc_edge_sync.sv
module intc_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic rise_sel,
    output logic edge_pulse
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = pin;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
        edge_pulse = rise_sel ? (st_q.s2 & ~st_q.prev) : (~st_q.s2 & st_q.prev);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: a detected edge lasts a single cycle
    assert_edge_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_pulse && $stable(rise_sel)) |=> !edge_pulse || $changed(rise_sel));
endmodule

// File: rtl/intc_flag_bank.sv
module intc_flag_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] flags
);
    typedef struct packed {
        logic [W-1:0] f;
    } bank_t;

    bank_t b_d, b_q;

    always_comb begin
        b_d   = b_q;
        b_d.f = (b_q.f & ~clr) | set;
        flags = b_q.f;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    // R3: a flag only falls after its clear strobe
    assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(flags) & ~$past(clr)) & ~flags) == '0));

    // R8: set wins over a simultaneous clear
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> (($past(set) & ~flags) == '0));
endmodule

// File: rtl/intc_top.sv
module intc_top
    import intc_pkg::*;
#(
    parameter int NUM_PER = 4,
    parameter int VEC_W   = 13,
    parameter logic [VEC_W-1:0] VECTOR = 13'h0004
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_pin,
    input  logic               ext_rise_sel,
    input  logic               tmr_wrap,
    input  logic               port_chg,
    input  logic [NUM_PER-1:0] per_req,
    input  logic [CORE_N-1:0]  core_en,
    input  logic [NUM_PER-1:0] per_en,
    input  logic               per_grp_en,
    input  logic [CORE_N-1:0]  core_clr,
    input  logic [NUM_PER-1:0] per_clr,
    input  logic               gie_wr,
    input  logic               gie_wdata,
    input  logic               irq_ack,
    input  logic               reti,
    output logic [CORE_N-1:0]  core_flags,
    output logic [NUM_PER-1:0] per_flags,
    output logic               gie,
    output logic               irq_cpu,
    output logic               wake,
    output logic [VEC_W-1:0]   vec_addr
);
    logic              ext_edge;
    logic [CORE_N-1:0] core_set;
    logic              core_any;
    logic              per_any;
    intc_state_t       st_d, st_q;

    intc_edge_sync u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin        (ext_pin),
        .rise_sel   (ext_rise_sel),
        .edge_pulse (ext_edge)
    );

    always_comb begin
        core_set            = '0;
        core_set[CORE_EXT]  = ext_edge;
        core_set[CORE_TMR]  = tmr_wrap;
        core_set[CORE_PORT] = port_chg;
    end

    intc_flag_bank #(.W(CORE_N)) u_core_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (core_set),
        .clr   (core_clr),
        .flags (core_flags)
    );

    intc_flag_bank #(.W(NUM_PER)) u_per_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (per_req),
        .clr   (per_clr),
        .flags (per_flags)
    );

    always_comb begin
        st_d = st_q;
        if (irq_ack)     st_d.gie = 1'b0;
        else if (reti)   st_d.gie = 1'b1;
        else if (gie_wr) st_d.gie = gie_wdata;

        core_any = |(core_flags & core_en);
        per_any  = per_grp_en & (|(per_flags & per_en));
        wake     = core_any | per_any;
        irq_cpu  = wake & st_q.gie;
        vec_addr = irq_cpu ? VECTOR : '0;
        gie      = st_q.gie;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: CPU line needs the global enable
    assert_irq_needs_gie_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cpu |-> gie);

    // R6: every CPU request is also a wake request
    assert_irq_implies_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cpu |-> wake);

    // R7: group enable low blocks peripheral-only requests
    assert_group_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!per_grp_en && ((core_flags & core_en) == '0)) |-> !wake);

    // R9: acknowledge leaves the global enable low
    assert_ack_clears_gie_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !gie);

    // R10: vector only presented with a request
    assert_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_cpu |-> (vec_addr == '0));
endmodule

// File: tb/tb_intc_top.sv
`timescale 1ns/1ps
module tb_intc_top;
    localparam int NP = 4;

    logic clk = 0;
    logic rst_n = 0;
    logic ext_pin = 0, ext_rise_sel = 1, tmr_wrap = 0, port_chg = 0;
    logic [NP-1:0] per_req = '0, per_en = '0, per_clr = '0;
    logic [2:0] core_en = '0, core_clr = '0;
    logic per_grp_en = 0, gie_wr = 0, gie_wdata = 0, irq_ack = 0, reti = 0;
    logic [2:0] core_flags;
    logic [NP-1:0] per_flags;
    logic gie, irq_cpu, wake;
    logic [12:0] vec_addr;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    intc_top #(.NUM_PER(NP)) dut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_rise_sel(ext_rise_sel),
        .tmr_wrap(tmr_wrap), .port_chg(port_chg), .per_req(per_req),
        .core_en(core_en), .per_en(per_en), .per_grp_en(per_grp_en),
        .core_clr(core_clr), .per_clr(per_clr), .gie_wr(gie_wr),
        .gie_wdata(gie_wdata), .irq_ack(irq_ack), .reti(reti),
        .core_flags(core_flags), .per_flags(per_flags), .gie(gie),
        .irq_cpu(irq_cpu), .wake(wake), .vec_addr(vec_addr)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_all();
        core_clr = '1; per_clr = '1;
        tick();
        core_clr = '0; per_clr = '0;
    endtask

    task automatic write_gie(input logic v);
        gie_wr = 1; gie_wdata = v;
        tick();
        gie_wr = 0;
    endtask

    // set core flags fm[2:0] and peripheral flags fm[6:3]
    task automatic set_flags(input logic [6:0] fm);
        ext_rise_sel = 1;
        ext_pin  = fm[0];
        tmr_wrap = fm[1];
        port_chg = fm[2];
        per_req  = fm[6:3];
        tick();
        tmr_wrap = 0; port_chg = 0; per_req = '0;
        tick(); tick(); tick();
        ext_pin = 0;
        tick(); tick(); tick();
    endtask

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic exp_w, exp_i;
        @(negedge clk); tick(); tick();
        // R11 reset state
        chk("R11 flags", {core_flags, per_flags}, '0);
        chk("R11 gie/irq/wake", {gie, irq_cpu, wake}, '0);
        chk("R11 vec", vec_addr, '0);
        rst_n = 1;
        tick();

        // R2 latency: pin changes between edges
        ext_rise_sel = 1;
        ext_pin = 1;
        tick(); tick();
        chk("R2 not after 2nd edge", core_flags[0], 0);
        tick();
        chk("R2 set after 3rd edge", core_flags[0], 1);
        ext_pin = 0;
        repeat (5) tick();
        chk("R3 sticky after pin low", core_flags[0], 1);
        core_clr = 3'b001; tick(); core_clr = '0;
        chk("R3 cleared by strobe", core_flags[0], 0);

        // R1 falling select ignores rising edge
        ext_rise_sel = 0;
        ext_pin = 1; repeat (5) tick();
        chk("R1 rising ignored when falling sel", core_flags[0], 0);
        ext_pin = 0; repeat (4) tick();
        chk("R1 falling edge sets flag", core_flags[0], 1);
        clear_all();
        ext_rise_sel = 1;
        ext_pin = 1; repeat (4) tick();
        ext_pin = 0; repeat (4) tick();
        chk("R1 falling ignored when rising sel", core_flags[0], 1);
        clear_all();

        // R8 set wins over clear
        tmr_wrap = 1; core_clr = 3'b010; per_req = 4'b0100; per_clr = 4'b0100;
        tick();
        tmr_wrap = 0; core_clr = '0; per_req = '0; per_clr = '0;
        chk("R8 core set wins", core_flags[1], 1);
        chk("R8 per set wins", per_flags[2], 1);
        clear_all();

        // R9 gie priority
        chk("R9 gie reset 0", gie, 0);
        reti = 1; gie_wr = 1; gie_wdata = 0; tick(); reti = 0; gie_wr = 0;
        chk("R9 reti beats write", gie, 1);
        irq_ack = 1; reti = 1; tick(); irq_ack = 0; reti = 0;
        chk("R9 ack beats reti", gie, 0);
        write_gie(1);
        chk("R9 write sets", gie, 1);
        irq_ack = 1; tick(); irq_ack = 0;
        chk("R9 ack clears", gie, 0);

        // R4/R5/R6/R7/R10 near-exhaustive sweep
        for (int fm = 0; fm < 128; fm++) begin
            clear_all();
            set_flags(fm[6:0]);
            chk("R4 flags latched", {per_flags, core_flags}, fm);
            for (int g = 0; g < 2; g++) begin
                write_gie(g[0]);
                for (int en = 0; en < 256; en++) begin
                    core_en = en[2:0];
                    per_grp_en = en[3];
                    per_en = en[7:4];
                    #0.2;
                    exp_w = (|(fm[2:0] & en[2:0])) | (en[3] & (|(fm[6:3] & en[7:4])));
                    exp_i = exp_w & g[0];
                    chk("R5/R6/R7 irq,wake", {irq_cpu, wake}, {exp_i, exp_w});
                    chk("R10 vector", vec_addr, exp_i ? 32'h4 : 32'h0);
                end
                core_en = '0; per_en = '0; per_grp_en = 0;
                @(negedge clk);
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule